// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block is a small bank of 32-bit registers that configures an analog storage-card PHY and reports its two readiness flags. It sits on a simple memory-mapped bus. Each transfer lasts one cycle and there are no wait states. Seven control words each hold 16 bits of state. An eighth word is read-only and shows whether pad calibration has finished and whether the delay-locked loop has locked.

Every write carries its own per-bit enable. The upper half of the write word selects which bits of the lower half are stored. Software can therefore change one field, such as the tap delay, in a single write and leave every other bit of that word untouched. There is no read-modify-write sequence and no race with other writers. The field outputs drive the PHY directly: power-on, loop enable, drive strength, frequency band, output tap delay enable and output tap delay select.

The bus has no back-pressure. Every request with `bus_valid` high is accepted on the rising edge where it is sampled. Read data comes back on the following cycle, flagged by `bus_rvalid`. No ready signal exists, so a requester may issue one transfer every cycle.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On an accepted write, stored bit x (0 to 15) of the addressed control word takes write-data bit x only when write-data bit x+16 is 1; every other stored bit keeps its value, and a cycle with no write to a word leaves it unchanged.
- R2: The control words are decoded from bus_addr[5:2] as indices 0 to 6, which are byte offsets 0x00 to 0x18; bus_addr[1:0] are ignored. A read of a control word returns its 16 stored bits in bits 15:0 and zeros in bits 31:16.
- R3: A read of index 8 (offset 0x20) returns calibration-done in bit 6 and loop-ready in bit 5, with every other bit 0. A flag level sampled at clock edge N is returned by reads accepted at edge N+2 or later; reads accepted at edge N or N+1 still return the old value.
- R4: Writes to index 7 and to indices 8 to 15 change no stored bit. Reads of index 7 and of indices 9 to 15 return 0.
- R5: In control word 6 (offset 0x18), bit 0 drives pwr_on (1 means powered), bit 1 drives dll_en, and bits 6:4 drive drv_str. The drive codes are 0 for 50 ohm, 1 for 33 ohm, 2 for 66 ohm, 3 for 100 ohm and 4 for 40 ohm.
- R6: In control word 0 (offset 0x00), bits 13:12 drive freq_sel, bit 11 drives otap_en, and bits 10:7 drive otap_sel.
- R7: After reset every control bit is 0. The PHY therefore starts powered down with the loop disabled, and bus_rvalid is 0.
- R8: Field outputs reflect a write from the clock edge that accepts it. bus_rvalid is 1 in exactly the cycle after an accepted read, and bus_rdata holds that read's value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Transfer request, accepted every cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Enable mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| cal_done_in | input | 1 | Asynchronous calibration-done flag |
| dll_ready_in | input | 1 | Asynchronous loop-lock flag |
| pwr_on | output | 1 | PHY power-on (active high) |
| dll_en | output | 1 | Loop enable |
| drv_str | output | 3 | Drive strength code |
| freq_sel | output | 2 | Loop frequency band |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |

## Verification
A write changes the field outputs at the edge that accepts it, so the bench checks the fields at the next falling edge after a write. Read data is registered once, and the bench compares bus_rdata and bus_rvalid at the falling edge one cycle after the request. The status flags cross two synchronizer flops ahead of that read register. The bench raises a flag and then issues reads accepted at the first, second and third edges after the change: the first two must return the old value and the third the new one.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;

  localparam int PWR_BIT   = 0;
  localparam int DLLEN_BIT = 1;
  localparam int DRV_LSB   = 4;
  localparam int DRV_W     = 3;

  localparam int OSEL_LSB  = 7;
  localparam int OSEL_W    = 4;
  localparam int OEN_BIT   = 11;
  localparam int FSEL_LSB  = 12;
  localparam int FSEL_W    = 2;

  localparam int CAL_BIT   = 6;
  localparam int LOCK_BIT  = 5;

  typedef enum logic [DRV_W-1:0] {
    DRV_50  = 3'd0,
    DRV_33  = 3'd1,
    DRV_66  = 3'd2,
    DRV_100 = 3'd3,
    DRV_40  = 3'd4
  } drv_code_e;
endpackage

// File: rtl/masked_word.sv
module masked_word #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);
  logic [W-1:0] mask;
  assign mask = wdata[2*W-1:W];

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= (q & ~mask) | (wdata[W-1:0] & mask);
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
endmodule

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_sync_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] != $past(q[i])) |-> (q[i] == $past(d[i], 2)));
  end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
#(
  parameter int NUM_CTRL = 7,
  parameter int ADDR_W   = 6,
  parameter int STAT_IDX = 8,
  parameter int PWR_IDX  = 6,
  parameter int TAP_IDX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              cal_done_in,
  input  logic              dll_ready_in,
  output logic              pwr_on,
  output logic              dll_en,
  output logic [2:0]        drv_str,
  output logic [1:0]        freq_sel,
  output logic              otap_en,
  output logic [3:0]        otap_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]             idx;
  logic [NUM_CTRL*HALF_W-1:0]   ctrl_flat;
  logic [HALF_W-1:0]            pwr_word, tap_word;
  logic [1:0]                   stat_sync;
  logic [BUS_W-1:0]             rd_mux;
  logic                         rd_req, wr_req;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid && bus_write;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_word
    masked_word #(.W(HALF_W)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_req && (idx == IDX_W'(i))),
      .wdata (bus_wdata),
      .q     (ctrl_flat[i*HALF_W +: HALF_W])
    );
  end

  flag_sync #(.N(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cal_done_in, dll_ready_in}),
    .q     (stat_sync)
  );

  assign pwr_word = ctrl_flat[PWR_IDX*HALF_W +: HALF_W];
  assign tap_word = ctrl_flat[TAP_IDX*HALF_W +: HALF_W];

  assign pwr_on   = pwr_word[PWR_BIT];
  assign dll_en   = pwr_word[DLLEN_BIT];
  assign drv_str  = pwr_word[DRV_LSB +: DRV_W];
  assign freq_sel = tap_word[FSEL_LSB +: FSEL_W];
  assign otap_en  = tap_word[OEN_BIT];
  assign otap_sel = tap_word[OSEL_LSB +: OSEL_W];

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (idx == IDX_W'(i)) rd_mux[HALF_W-1:0] = ctrl_flat[i*HALF_W +: HALF_W];
    end
    if (idx == IDX_W'(STAT_IDX)) begin
      rd_mux[CAL_BIT]  = stat_sync[1];
      rd_mux[LOCK_BIT] = stat_sync[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  p_rd_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata[BUS_W-1:HALF_W] == '0));
  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (idx >= IDX_W'(NUM_CTRL))) |=> $stable(ctrl_flat));
  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  p_no_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
endmodule

// File: tb/sim_phy_ctl_regbank.sv
module sim_phy_ctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        cal_done_in = 1'b0, dll_ready_in = 1'b0;
  logic        pwr_on, dll_en, otap_en;
  logic [2:0]  drv_str;
  logic [1:0]  freq_sel;
  logic [3:0]  otap_sel;

  int checks = 0, failures = 0;
  logic [15:0] mdl [7];
  logic done = 1'b0;

  always #10 clk = ~clk;

  phy_ctl_regbank u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    logic [3:0] i = a[5:2];
    if (i < 7) return {16'h0, mdl[i]};
    if (i == 8) return {25'h0, cal_done_in, dll_ready_in, 5'h0};
    return 32'h0;
  endfunction

  task automatic check_fields(input string tag);
    check(pwr_on == mdl[6][0], {tag, " R5 pwr_on"}, 32'(pwr_on), 32'(mdl[6][0]));
    check(dll_en == mdl[6][1], {tag, " R5 dll_en"}, 32'(dll_en), 32'(mdl[6][1]));
    check(drv_str == mdl[6][6:4], {tag, " R5 drv_str"}, 32'(drv_str), 32'(mdl[6][6:4]));
    check(freq_sel == mdl[0][13:12], {tag, " R6 freq_sel"}, 32'(freq_sel), 32'(mdl[0][13:12]));
    check(otap_en == mdl[0][11], {tag, " R6 otap_en"}, 32'(otap_en), 32'(mdl[0][11]));
    check(otap_sel == mdl[0][10:7], {tag, " R6 otap_sel"}, 32'(otap_sel), 32'(mdl[0][10:7]));
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    logic [3:0] i = a[5:2];
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (i < 7) mdl[i] = (mdl[i] & ~d[31:16]) | (d[15:0] & d[31:16]);
    check_fields("R1 R8 after write");
  endtask

  task automatic do_read(input logic [5:0] a, input logic [31:0] exp, input string req);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check(bus_rvalid == 1'b1, {req, " R8 rvalid"}, 32'(bus_rvalid), 32'h1);
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 7; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(bus_rvalid == 1'b0, "R7 rvalid after reset", 32'(bus_rvalid), 32'h0);
    check_fields("R7 reset");
    for (int i = 0; i < 7; i++) do_read(6'(i*4), 32'h0, "R7 control word reset");
    @(negedge clk);
    check(bus_rvalid == 1'b0, "R8 rvalid idle", 32'(bus_rvalid), 32'h0);

    // R1 directed: mask zero changes nothing, single field update
    do_write(6'h00, 32'h0000_ffff);
    do_read(6'h00, 32'h0, "R1 zero mask keeps word");
    do_write(6'h00, 32'h0780_0200);  // otap_sel = 4
    check(otap_sel == 4'd4, "R6 otap_sel directed", 32'(otap_sel), 32'h4);
    do_write(6'h00, 32'h3800_3800);  // freq 3, otap_en 1
    check(otap_sel == 4'd4 && freq_sel == 2'd3 && otap_en,
          "R1 R6 neighbour field kept", {24'h0, freq_sel, otap_en, otap_sel, 1'b0}, 32'h000000e8);
    // R5 drive codes and power
    do_write(6'h18, 32'h0073_0043);
    check(drv_str == 3'(phy_ctl_pkg::DRV_40) && pwr_on && dll_en, "R5 drive 40 ohm, powered",
          {28'h0, drv_str, pwr_on}, 32'h9);
    // R2 low address bits ignored, upper read bits zero
    do_write(6'h0b, 32'hffff_a5c3);
    do_read(6'h08, 32'h0000_a5c3, "R2 low address bits ignored");
    // R4 writes to status and unmapped indices
    do_write(6'h1c, 32'hffff_ffff);
    do_write(6'h20, 32'hffff_ffff);
    do_write(6'h3c, 32'hffff_ffff);
    do_read(6'h1c, 32'h0, "R4 unmapped index 7 reads zero");
    do_read(6'h3c, 32'h0, "R4 unmapped index 15 reads zero");
    for (int i = 0; i < 7; i++) do_read(6'(i*4), {16'h0, mdl[i]}, "R4 words kept after ignored writes");

    // R3 synchronizer lag
    cal_done_in = 1'b1; dll_ready_in = 1'b1;
    do_read(6'h20, 32'h0, "R3 status edge N old");
    do_read(6'h20, 32'h0, "R3 status edge N+1 old");
    do_read(6'h20, 32'h0000_0060, "R3 status edge N+2 new");
    dll_ready_in = 1'b0;
    repeat (3) @(negedge clk);
    do_read(6'h20, 32'h0000_0040, "R3 cal done only");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] a = {4'($urandom_range(0, 15)), 2'($urandom)};
      if (($urandom % 8) == 0) begin
        cal_done_in = 1'($urandom); dll_ready_in = 1'($urandom);
        repeat (3) @(negedge clk);
      end
      if ($urandom % 2) do_write(a, $urandom);
      else do_read(a, exp_read(a), "R2 R3 R4 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule